// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is a two-wire serial slave that owns a set of one or two 8-bit wiper registers, together with a shutdown flag and two general-purpose logic outputs. It runs on a system clock. It samples the bus clock and data lines through a short synchronizer and finds START, repeated START and STOP from their edges. It answers only the 7-bit address formed by a fixed five-bit prefix and two strap pins, so four copies can share one bus.

A write carries one packed instruction byte and then any number of data bytes. The instruction byte selects the channel and can request a midscale preset, set or clear shutdown, and set the two logic outputs. Each data byte that follows loads the selected wiper. A read returns the wiper of the channel chosen by the most recent instruction byte. There is no pointer byte in the read frame. The block pulls SDA low only through an open-drain enable. It pulses a strobe on every applied byte and reports which channel that byte addressed.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0101 1 followed by strap_i[1] and strap_i[0]. Bit 0 of that byte is the direction (1 = read). On a mismatch the slave never drives SDA and changes no register until the next START.
- R2: After reset, every wiper holds 0x80, shdn_o and gpo_o are 0, and sda_oe_o is 0.
- R3: The first byte after a write address is the instruction. Bit 7 selects the channel (0 = first, 1 = second), bit 6 presets the selected wiper to 0x80, bit 5 is copied to shdn_o, bit 4 to gpo_o[0] and bit 3 to gpo_o[1]. Bits 2..0 are ignored. The instruction byte is acknowledged.
- R4: Each data byte after the instruction is acknowledged and loads the selected wiper. Later data bytes in the same transaction reuse that instruction. Every applied byte pulses upd_stb_o once.
- R5: A write that ends right after the instruction byte, by STOP or by repeated START, still applies the shutdown, logic-output and preset fields, and changes no wiper value otherwise.
- R6: In a read, the slave drives the selected wiper MSB first right after acknowledging the address. A master NACK ends the transfer.
- R7: A repeated START without STOP is accepted, so a write of only an instruction byte can be followed directly by a read of that channel.
- R8: A START or STOP in the middle of a byte aborts it. A partly received byte is never applied, and SDA is released.
- R9: With NCH = 1, instruction bit 7 is ignored and the single wiper is always addressed.
- R10: sda_oe_o changes only while SCL is low, except for the release forced by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap bits, [1] then [0] in the address |
| wiper_o | output | NCH*8 | Wiper registers, channel 0 in bits 7..0 |
| shdn_o | output | 1 | Shutdown flag from the instruction byte |
| gpo_o | output | 2 | General-purpose logic outputs |
| upd_stb_o | output | 1 | One-cycle pulse when a byte has been applied |
| upd_chan_o | output | 1 | Channel addressed by the latest applied byte |

## Verification
A table of write transactions walks both channels. Each entry mixes the instruction flags so that a swapped channel bit, a shifted output bit or a dropped preset shows up in a different output. Each entry is followed by a readback, which separates the selected-channel pointer from the wiper contents. Directed sequences cover the remaining cases: a wrong address, an instruction with no data, a stream of data bytes, a repeated START into a read, and bytes cut off by STOP or START. A second single-channel instance on the same bus checks that the channel bit is ignored, and that devices with other strap values stay silent.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   typedef enum logic [2:0] {
      LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_WR_BYTE,
      LS_WR_ACK, LS_RD_BYTE, LS_RD_ACK, LS_SKIP
   } link_state_e;

   localparam int INS_CHAN = 7;
   localparam int INS_MID  = 6;
   localparam int INS_SD   = 5;
   localparam int INS_GP0  = 4;
   localparam int INS_GP1  = 3;
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_s, scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_s;
         sda_d    <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_i2c_link.sv
module dpot_i2c_link
   import dpot_pkg::*;
#(
   parameter int         DW      = 8,
   parameter int         STRAP_W = 2,
   parameter logic [4:0] ADDR_HI = 5'b01011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [DW-1:0]      rd_data_i,
   output logic               sda_oe_o,
   output logic               byte_stb_o,
   output logic               byte_first_o,
   output logic [DW-1:0]      byte_o
);
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DW);
   localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);
   localparam logic [CW-1:0] CNT_ONE  = CW'(1);

   link_state_e   state;
   logic [CW-1:0] cnt;
   logic [DW-1:0] rx;
   logic [DW-2:0] tx;
   logic          rw, first, acked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LS_IDLE;  cnt <= '0;  rx <= '0;  tx <= '0;
         rw <= 1'b0;  first <= 1'b0;  acked <= 1'b0;
         sda_oe_o <= 1'b0;  byte_stb_o <= 1'b0;
         byte_first_o <= 1'b0;  byte_o <= '0;
      end else begin
         byte_stb_o <= 1'b0;
         if (start_det) begin
            state <= LS_ADDR;  cnt <= '0;  sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            state <= LS_IDLE;  cnt <= '0;  sda_oe_o <= 1'b0;
         end else begin
            case (state)
               LS_ADDR, LS_WR_BYTE: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     rx  <= {rx[DW-2:0], sda_s};
                     cnt <= cnt + CNT_ONE;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (state == LS_ADDR) begin
                        if (rx[DW-1:1] == {ADDR_HI, strap_i}) begin
                           sda_oe_o <= 1'b1;
                           rw       <= rx[0];
                           first    <= 1'b1;
                           state    <= LS_ADDR_ACK;
                        end else begin
                           state <= LS_SKIP;
                        end
                     end else begin
                        sda_oe_o     <= 1'b1;
                        byte_stb_o   <= 1'b1;
                        byte_first_o <= first;
                        byte_o       <= rx;
                        first        <= 1'b0;
                        state        <= LS_WR_ACK;
                     end
                  end
               end
               LS_ADDR_ACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     tx       <= rd_data_i[DW-2:0];
                     sda_oe_o <= ~rd_data_i[DW-1];
                     state    <= LS_RD_BYTE;
                  end else begin
                     sda_oe_o <= 1'b0;
                     state    <= LS_WR_BYTE;
                  end
               end
               LS_WR_ACK: if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  state    <= LS_WR_BYTE;
               end
               LS_RD_BYTE: if (scl_fall) begin
                  if (cnt == CNT_LAST) begin
                     sda_oe_o <= 1'b0;
                     cnt      <= '0;
                     state    <= LS_RD_ACK;
                  end else begin
                     cnt      <= cnt + CNT_ONE;
                     sda_oe_o <= ~tx[DW-2];
                     tx       <= {tx[DW-3:0], 1'b0};
                  end
               end
               LS_RD_ACK: begin
                  if (scl_rise) begin
                     acked <= ~sda_s;
                  end else if (scl_fall) begin
                     if (acked) begin
                        tx       <= rd_data_i[DW-2:0];
                        sda_oe_o <= ~rd_data_i[DW-1];
                        state    <= LS_RD_BYTE;
                     end else begin
                        state <= LS_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dpot_cmd_regs.sv
module dpot_cmd_regs
   import dpot_pkg::*;
#(
   parameter int NCH = 2,
   parameter int DW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic              byte_first,
   input  logic [DW-1:0]     byte_i,
   output logic [NCH*DW-1:0] wiper_o,
   output logic              shdn_o,
   output logic [1:0]        gpo_o,
   output logic              upd_stb_o,
   output logic              upd_chan_o,
   output logic [DW-1:0]     rd_data_o
);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

   logic          sel_q, chan_new, sel_eff;
   logic [DW-1:0] wiper_q [NCH];

   generate
      if (NCH == 1) begin : g_one
         assign chan_new  = 1'b0;
         assign rd_data_o = wiper_q[0];
      end else begin : g_two
         assign chan_new  = byte_i[INS_CHAN];
         assign rd_data_o = sel_q ? wiper_q[1] : wiper_q[0];
      end
   endgenerate

   assign sel_eff = byte_first ? chan_new : sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;  shdn_o <= 1'b0;  gpo_o <= 2'b00;
         upd_stb_o <= 1'b0;  upd_chan_o <= 1'b0;
      end else begin
         upd_stb_o <= byte_stb;
         if (byte_stb) begin
            upd_chan_o <= sel_eff;
            if (byte_first) begin
               sel_q  <= chan_new;
               shdn_o <= byte_i[INS_SD];
               gpo_o  <= {byte_i[INS_GP1], byte_i[INS_GP0]};
            end
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wiper_q[c] <= MID;
         end else if (byte_stb && sel_eff == 1'(c)) begin
            if (!byte_first)          wiper_q[c] <= byte_i;
            else if (byte_i[INS_MID]) wiper_q[c] <= MID;
         end
      end
      assign wiper_o[c*DW +: DW] = wiper_q[c];
   end
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
   parameter int         NCH         = 2,
   parameter int         DW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b01011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [1:0]        strap_i,
   output logic [NCH*DW-1:0] wiper_o,
   output logic              shdn_o,
   output logic [1:0]        gpo_o,
   output logic              upd_stb_o,
   output logic              upd_chan_o
);
   generate
      if (NCH < 1 || NCH > 2) begin : g_bad_nch
         $error("NCH must be 1 or 2");
      end
      if (DW != 8) begin : g_bad_dw
         $error("DW must be 8 to match the address and instruction layout");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          byte_stb, byte_first;
   logic [DW-1:0] byte_val, rd_data;

   dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   dpot_i2c_link #(.DW(DW), .STRAP_W(2), .ADDR_HI(ADDR_HI)) u_link (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .strap_i(strap_i), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
      .byte_stb_o(byte_stb), .byte_first_o(byte_first), .byte_o(byte_val)
   );

   dpot_cmd_regs #(.NCH(NCH), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb),
      .byte_first(byte_first), .byte_i(byte_val),
      .wiper_o(wiper_o), .shdn_o(shdn_o), .gpo_o(gpo_o),
      .upd_stb_o(upd_stb_o), .upd_chan_o(upd_chan_o), .rd_data_o(rd_data)
   );
endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk #(
   parameter int NCH = 2,
   parameter int DW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_o,
   input logic              start_det,
   input logic              stop_det,
   input logic              scl_fall,
   input logic              byte_stb,
   input logic              byte_first,
   input logic [NCH*DW-1:0] wiper_o,
   input logic              shdn_o,
   input logic [1:0]        gpo_o
);
   // R10: open-drain enable moves only in the low phase of SCL
   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && !$past(start_det || stop_det)) |-> !scl_i);

   // R10: bus events are mutually exclusive
   assert_events_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det, scl_fall}));

   // R8: a START always leaves SDA released
   assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_det) |-> !sda_oe_o);

   // R4: wipers move only after a completed byte
   assert_wiper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o) |-> $past(byte_stb));

   // R5: control outputs move only after an instruction byte
   assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({shdn_o, gpo_o}) |-> $past(byte_stb && byte_first));
endmodule

bind dpot_i2c_slave dpot_i2c_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
   .byte_stb(byte_stb), .byte_first(byte_first),
   .wiper_o(wiper_o), .shdn_o(shdn_o), .gpo_o(gpo_o)
);

// File: tb/dpot_i2c_slave_tb.sv
module dpot_i2c_slave_tb;
   localparam int Q = 10;
   localparam int NVEC = 6;
   // {instr, data, expected wiper0, expected wiper1, {5'b0, shdn, gpo[1], gpo[0]}}
   localparam logic [39:0] VEC [NVEC] = '{
      40'h00_3C_3C_80_00,
      40'h80_A5_3C_A5_00,
      40'h90_FF_3C_FF_01,
      40'h08_00_00_FF_02,
      40'h27_5A_5A_FF_04,
      40'hC0_11_5A_11_00
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic oe0, oe1, sda_line;
   logic [15:0] w0v;
   logic [7:0]  w1v;
   logic sd0, sd1, stb0, stb1, ch0, ch1;
   logic [1:0] gp0, gp1;
   int n_run = 0, n_fail = 0, stb_cnt = 0;
   bit done = 1'b0;

   assign sda_line = sda_m & ~oe0 & ~oe1;

   dpot_i2c_slave #(.NCH(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(oe0), .strap_i(2'b10), .wiper_o(w0v), .shdn_o(sd0),
      .gpo_o(gp0), .upd_stb_o(stb0), .upd_chan_o(ch0)
   );

   dpot_i2c_slave #(.NCH(1)) u_dut1 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(oe1), .strap_i(2'b01), .wiper_o(w1v), .shdn_o(sd1),
      .gpo_o(gp1), .upd_stb_o(stb1), .upd_chan_o(ch1)
   );

   always @(posedge clk) if (stb0) stb_cnt <= stb_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; gap(Q); scl_m = 1'b1; gap(Q);
      sda_m = 1'b0; gap(Q); scl_m = 1'b0; gap(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; gap(Q); scl_m = 1'b1; gap(Q); sda_m = 1'b1; gap(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; gap(Q); scl_m = 1'b1; gap(2*Q); scl_m = 1'b0; gap(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; gap(Q); scl_m = 1'b1; gap(Q);
      ack = ~sda_line;
      gap(Q); scl_m = 1'b0; gap(Q);
   endtask

   task automatic read_byte(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         gap(Q); scl_m = 1'b1; gap(Q);
         b[i] = sda_line;
         gap(Q); scl_m = 1'b0; gap(Q);
      end
      send_bit(nack);
   endtask

   initial begin
      logic a;
      logic [7:0] rb;
      gap(5);
      rst_n = 1'b1;
      gap(5);
      // R2: reset state
      chk("R2 wipers", w0v, 16'h8080);
      chk("R2 single wiper", w1v, 8'h80);
      chk("R2 shdn/gpo", {sd0, gp0}, 3'b000);
      chk("R2 sda released", {oe0, oe1}, 2'b00);

      for (int k = 0; k < NVEC; k++) begin
         bus_start();
         send_byte(8'h5C, a);             chk("R1 address ack", a, 1);
         send_byte(VEC[k][39:32], a);     chk("R3 instruction ack", a, 1);
         send_byte(VEC[k][31:24], a);     chk("R4 data ack", a, 1);
         bus_stop();
         gap(4);
         chk("R4 wiper0", w0v[7:0], VEC[k][23:16]);
         chk("R4 wiper1", w0v[15:8], VEC[k][15:8]);
         chk("R3 shdn/gpo fields", {sd0, gp0}, VEC[k][2:0]);
         bus_start();
         send_byte(8'h5D, a);             chk("R6 read address ack", a, 1);
         read_byte(1'b1, rb);
         bus_stop();
         chk("R6 readback", rb, VEC[k][39] ? VEC[k][15:8] : VEC[k][23:16]);
      end

      // R1: unmatched strap bits, no ack, no effect
      bus_start();
      send_byte(8'h5E, a);  chk("R1 foreign address nack", a, 0);
      send_byte(8'h40, a);  chk("R1 no ack after mismatch", a, 0);
      send_byte(8'h99, a);
      bus_stop(); gap(4);
      chk("R1 wipers untouched", w0v, 16'h115A);
      chk("R1 controls untouched", {sd0, gp0}, 3'b000);

      // R5: instruction only, both logic outputs set
      bus_start();
      send_byte(8'h5C, a); send_byte(8'h18, a);
      bus_stop(); gap(4);
      chk("R5 gpo applied", gp0, 2'b11);
      chk("R5 wipers unchanged", w0v, 16'h115A);

      // R4: streamed data bytes reuse the instruction
      stb_cnt = 0;
      bus_start();
      send_byte(8'h5C, a); send_byte(8'h80, a);
      send_byte(8'h01, a); gap(4); chk("R4 stream byte 1", w0v[15:8], 8'h01);
      send_byte(8'h02, a); gap(4); chk("R4 stream byte 2", w0v[15:8], 8'h02);
      send_byte(8'h03, a); chk("R4 stream ack", a, 1);
      bus_stop(); gap(4);
      chk("R4 stream byte 3", w0v[15:8], 8'h03);
      chk("R4 wiper0 untouched", w0v[7:0], 8'h5A);
      chk("R4 strobe count", stb_cnt, 4);
      chk("R4 strobe channel", ch0, 1'b1);

      // R3: midscale preset alone
      bus_start();
      send_byte(8'h5C, a); send_byte(8'hC0, a);
      bus_stop(); gap(4);
      chk("R3 midscale preset", w0v[15:8], 8'h80);
      chk("R3 gpo cleared", gp0, 2'b00);

      // R7: select channel 0, repeated START into a read
      bus_start();
      send_byte(8'h5C, a); send_byte(8'h00, a);
      bus_start();
      send_byte(8'h5D, a); chk("R7 ack after repeated start", a, 1);
      read_byte(1'b1, rb);
      bus_stop();
      chk("R7 read selected channel", rb, 8'h5A);

      // R8: half byte cut by STOP
      bus_start();
      send_byte(8'h5C, a); send_byte(8'h00, a);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      bus_stop(); gap(4);
      chk("R8 stop abort keeps wiper0", w0v[7:0], 8'h5A);
      chk("R8 sda released", oe0, 1'b0);
      // R8: half byte cut by repeated START, then read channel 1
      bus_start();
      send_byte(8'h5C, a); send_byte(8'h80, a);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_start();
      send_byte(8'h5D, a); chk("R8 ack after abort", a, 1);
      read_byte(1'b1, rb);
      bus_stop();
      chk("R8 start abort readback", rb, 8'h80);
      chk("R8 wipers intact", w0v, 16'h805A);

      // R9: single-channel instance ignores the channel bit
      bus_start();
      send_byte(8'h5A, a); chk("R9 single ack", a, 1);
      send_byte(8'h80, a); send_byte(8'h77, a);
      bus_stop(); gap(4);
      chk("R9 single wiper written", w1v, 8'h77);
      chk("R1 other device untouched", w0v, 16'h805A);
      bus_start();
      send_byte(8'h5B, a); read_byte(1'b1, rb);
      bus_stop();
      chk("R9 single readback", rb, 8'h77);
      chk("R10 bus idle released", {oe0, oe1}, 2'b00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule